// File: doc/BRIEF.md
# Five-Lane Scrambled Pseudo-Random Word Generator

This block produces 32-bit pseudo-random words from five free-running linear-feedback shift registers. The registers have coprime lengths and are built in two different forms. Three use an external feedback XOR that shifts in at the bottom. Two use internal XOR taps on the shift path. On every request, the current state of all five registers is rotated, merged and passed through a small nonlinear term. The result is returned as one word.

A single noise bit enters the feedback of one register on every clock. When a real entropy source drives that bit, the sequence cannot be predicted. When the bit is held low, the output is fully repeatable from a seed. Software or a higher-level engine seeds the generator through a 32-bit seed port. It then requests as many words as it needs, one per request, and may issue requests back to back to form a stream of any length.

Top module: `prng_mix_top`

## Requirements
- R1: While `rst_n` is low, `rand_valid` is 0 and `rand_word` is 0. Every lane register holds the value 1.
- R2: `rand_valid` is 1 in exactly those cycles that follow a clock edge at which `req` was 1.
- R3: At a clock edge where `req` is 1, `rand_word` takes the scrambled value of the lane states held just before that edge. At any other edge, `rand_word` keeps its value.
- R4: The lanes are named A to E, with lengths 31, 29, 23, 19 and 17 bits. A, C and E are external-feedback (Fibonacci) lanes. B and D are internal-XOR (Galois) lanes. The tap masks are A 0x48000000, B 0x08000001, C 0x00420000, D 0x00000027 and E 0x00012000.
- R5: A Fibonacci lane of length L steps as follows. It computes the feedback bit as the XOR of (state AND mask). It then forms the next state as (state << 1) OR feedback, masked to L bits.
- R6: A Galois lane of length L steps as follows. It shifts the state left by one. If the old bit L-1 was set, it XORs in the mask. The result is masked to L bits.
- R7: On every clock, `noise_bit` is XORed into the feedback bit of lane A and of no other lane. A different noise history after the same seed yields a different word.
- R8: When `seed_load` is 1 at an edge, lane i (A=0 … E=4) loads `seed_data` rotated left by 7*i bits and masked to its length, instead of stepping. A request in the same cycle returns the pre-load state.
- R9: Whenever a lane's next value (loaded or stepped) would be all zeros, the lane takes the value 1. No lane ever holds zero, and an all-zero seed is safe.
- R10: The scrambled word is built from the lane states zero-extended to 32 bits, written A, B, C, D, E. It is A ^ rotl(B,5) ^ rotl(C,11) ^ rotl(D,17) ^ rotl(E,23) ^ (rotl(A,3) & rotl(B,13)).
- R11: Lanes advance on every clock, whether or not `req` is asserted. Back-to-back requests return a fresh word every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load all lanes from `seed_data` at this edge |
| seed_data | input | 32 | Seed value, spread across lanes by rotation |
| noise_bit | input | 1 | Entropy bit folded into lane A feedback |
| req | input | 1 | Request one random word |
| rand_valid | output | 1 | Word on `rand_word` is fresh this cycle |
| rand_word | output | 32 | Scrambled random word |

## Verification
The properties assume that `req`, `seed_load` and `noise_bit` are clean, synchronous levels that change only between clock edges. They take no assumption about how often requests come or how seeds are spaced. The shift properties of lanes A and B rely on one fact: a cycle without `seed_load` is a plain step, so the stimulus leaves gaps between seed loads. The stimulus drives all inputs on the falling edge. It mixes request bursts, sparse requests, seed loads that coincide with requests, an all-zero seed and a varying noise pattern, and stays within these assumptions throughout.

// File: rtl/prng_mix_pkg.sv
package prng_mix_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_LANES  = 5;
    localparam int NOISE_LANE = 0;
    localparam int SEED_ROT   = 7;
    localparam int NL_ROT_A   = 3;
    localparam int NL_ROT_B   = 13;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NUM_LANES-1:0][WORD_W-1:0] lane_vec_t;

    localparam int LANE_LEN [NUM_LANES] = '{31, 29, 23, 19, 17};
    localparam int MIX_ROT  [NUM_LANES] = '{0, 5, 11, 17, 23};
    localparam logic [NUM_LANES-1:0] LANE_GALOIS = 5'b01010;
    localparam word_t LANE_TAPS [NUM_LANES] = '{
        32'h4800_0000, 32'h0800_0001, 32'h0042_0000, 32'h0000_0027, 32'h0001_2000
    };

    typedef struct packed {
        logic  valid;
        word_t word;
    } out_st_t;

    function automatic word_t rotl(word_t x, int n);
        int k;
        k = n % WORD_W;
        if (k == 0) return x;
        return (x << k) | (x >> (WORD_W - k));
    endfunction

endpackage

// File: rtl/prng_lane_fib.sv
module prng_lane_fib
    import prng_mix_pkg::*;
#(
    parameter int    LEN  = 31,
    parameter word_t TAPS = 32'h4800_0000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  word_t seed_i,
    input  logic  noise_i,
    output word_t state_o
);
    localparam logic [63:0] FULL_MASK = (64'd1 << LEN) - 64'd1;
    localparam word_t LEN_MASK = FULL_MASK[WORD_W-1:0];

    word_t state_d, state_q;
    word_t cand;
    logic  fb;

    always_comb begin
        fb = (^(state_q & TAPS)) ^ noise_i;
        if (load_i) cand = seed_i & LEN_MASK;
        else        cand = {state_q[WORD_W-2:0], fb} & LEN_MASK;
        state_d = (cand == '0) ? word_t'(1) : cand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= word_t'(1);
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/prng_lane_gal.sv
module prng_lane_gal
    import prng_mix_pkg::*;
#(
    parameter int    LEN  = 29,
    parameter word_t TAPS = 32'h0800_0001
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  word_t seed_i,
    output word_t state_o
);
    localparam logic [63:0] FULL_MASK = (64'd1 << LEN) - 64'd1;
    localparam word_t LEN_MASK = FULL_MASK[WORD_W-1:0];

    word_t state_d, state_q;
    word_t cand;

    always_comb begin
        if (load_i) cand = seed_i & LEN_MASK;
        else        cand = ({state_q[WORD_W-2:0], 1'b0} ^ (state_q[LEN-1] ? TAPS : '0)) & LEN_MASK;
        state_d = (cand == '0) ? word_t'(1) : cand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= word_t'(1);
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/prng_scrambler.sv
module prng_scrambler
    import prng_mix_pkg::*;
(
    input  lane_vec_t lanes_i,
    output word_t     word_o
);
    word_t mix;
    word_t nonlin;

    always_comb begin
        mix = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            mix = mix ^ rotl(lanes_i[i], MIX_ROT[i]);
        end
        nonlin = rotl(lanes_i[0], NL_ROT_A) & rotl(lanes_i[1], NL_ROT_B);
        word_o = mix ^ nonlin;
    end
endmodule

// File: rtl/prng_mix_top.sv
module prng_mix_top
    import prng_mix_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_load,
    input  logic [31:0] seed_data,
    input  logic        noise_bit,
    input  logic        req,
    output logic        rand_valid,
    output logic [31:0] rand_word
);
    lane_vec_t lane_q;
    word_t     scr_word;
    out_st_t   out_d, out_q;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        word_t seed_lane;
        assign seed_lane = rotl(seed_data, SEED_ROT * i);
        if (LANE_GALOIS[i]) begin : g_gal
            prng_lane_gal #(.LEN(LANE_LEN[i]), .TAPS(LANE_TAPS[i])) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (seed_load),
                .seed_i (seed_lane),
                .state_o(lane_q[i])
            );
        end else begin : g_fib
            logic lane_noise;
            assign lane_noise = (i == NOISE_LANE) ? noise_bit : 1'b0;
            prng_lane_fib #(.LEN(LANE_LEN[i]), .TAPS(LANE_TAPS[i])) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (seed_load),
                .seed_i (seed_lane),
                .noise_i(lane_noise),
                .state_o(lane_q[i])
            );
        end
    end

    prng_scrambler u_scr (
        .lanes_i(lane_q),
        .word_o (scr_word)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req;
        if (req) out_d.word = scr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rand_valid = out_q.valid;
    assign rand_word  = out_q.word;
endmodule

// File: rtl/prng_mix_chk.sv
module prng_mix_chk
    import prng_mix_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      req,
    input logic      seed_load,
    input logic      rand_valid,
    input word_t     rand_word,
    input lane_vec_t lanes
);
    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rand_valid);

    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rand_valid);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(rand_word));

    // R5
    fib_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |=> (lanes[0][30:1] == $past(lanes[0][29:0])));

    // R6
    gal_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !lanes[1][28]) |=> (lanes[1] == ($past(lanes[1]) << 1)));

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_nz
        // R9
        lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lanes[i] != '0);
    end
endmodule

bind prng_mix_top prng_mix_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .seed_load (seed_load),
    .rand_valid(rand_valid),
    .rand_word (rand_word),
    .lanes     (lane_q)
);

// File: tb/prng_mix_top_tb_top.sv
`timescale 1ns/1ps
module prng_mix_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed_data = '0;
    logic        noise_bit = 1'b0;
    logic        req = 1'b0;
    logic        rand_valid;
    logic [31:0] rand_word;

    always #10 clk = ~clk;

    prng_mix_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_data (seed_data),
        .noise_bit (noise_bit),
        .req       (req),
        .rand_valid(rand_valid),
        .rand_word (rand_word)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R3 R4 R5 R6 R10";
    logic        pend_req = 1'b0;
    logic [31:0] held_word = '0;
    bit          mon_on = 0;

    int          lens [5] = '{31, 29, 23, 19, 17};
    bit          gal  [5] = '{0, 1, 0, 1, 0};
    logic [31:0] taps [5] = '{32'h4800_0000, 32'h0800_0001, 32'h0042_0000,
                              32'h0000_0027, 32'h0001_2000};
    logic [31:0] m [5] = '{32'd1, 32'd1, 32'd1, 32'd1, 32'd1};

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        int k = n % 32;
        if (k == 0) return x;
        return (x << k) | (x >> (32 - k));
    endfunction

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = m[0] ^ rl(m[1], 5) ^ rl(m[2], 11) ^ rl(m[3], 17) ^ rl(m[4], 23);
        return w ^ (rl(m[0], 3) & rl(m[1], 13));
    endfunction

    function automatic logic [31:0] lane_next(int i, logic [31:0] s, logic ld,
                                              logic [31:0] sd, logic nz);
        logic [63:0] fm = (64'd1 << lens[i]) - 64'd1;
        logic [31:0] msk = fm[31:0];
        logic [31:0] c;
        logic        fb;
        if (ld) c = rl(sd, 7 * i) & msk;
        else if (gal[i]) c = ((s << 1) ^ (s[lens[i]-1] ? taps[i] : 32'd0)) & msk;
        else begin
            fb = (^(s & taps[i])) ^ ((i == 0) ? nz : 1'b0);
            c  = ((s << 1) | {31'd0, fb}) & msk;
        end
        return (c == 0) ? 32'd1 : c;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus, pushes the expected word, steps the model
    task automatic cyc(logic ld, logic [31:0] sd, logic nz, logic rq);
        seed_load = ld;
        seed_data = sd;
        noise_bit = nz;
        req       = rq;
        pend_req  = rq;
        if (rq) begin
            exp_q.push_back(model_word());
            tag_q.push_back(cur_tag);
        end
        for (int i = 0; i < 5; i++) m[i] = lane_next(i, m[i], ld, sd, nz);
        @(negedge clk);
    endtask

    // monitor: compares outputs one step after each rising edge
    always @(posedge clk) begin
        #1;
        if (mon_on && rst_n && !done) begin
            chk(rand_valid == pend_req, "R2 valid timing", {31'd0, rand_valid}, {31'd0, pend_req});
            if (rand_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected word", rand_word, 32'd0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rand_word == e, t, rand_word, e);
                end
            end else begin
                chk(rand_word == held_word, "R3 hold without request", rand_word, held_word);
            end
            held_word = rand_word;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] w_quiet, w_noisy;
        logic [31:0] lcg = 32'hACE1_2345;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rand_valid == 1'b0, "R1 valid in reset", {31'd0, rand_valid}, 32'd0);
        chk(rand_word == 32'd0, "R1 word in reset", rand_word, 32'd0);
        rst_n  = 1'b1;
        mon_on = 1;

        // R1 R10: words straight from the reset lane values
        cur_tag = "R1 R10 from reset";
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);

        // R8 seed, then R11 back-to-back burst
        cur_tag = "R8 seed load";
        cyc(1, 32'h1234_5678, 0, 0);
        cur_tag = "R11 R4 R5 R6 R10 burst";
        for (int k = 0; k < 40; k++) cyc(0, 0, 0, 1);

        // R3 sparse requests with holds in between
        cur_tag = "R3 sparse";
        for (int k = 0; k < 30; k++) cyc(0, 0, 0, (k % 3) == 0);

        // R8 load and request in same cycle returns pre-load state
        cur_tag = "R8 load with request";
        cyc(1, 32'hDEAD_BEEF, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);

        // R9 all-zero seed
        cur_tag = "R9 zero seed";
        cyc(1, 32'd0, 0, 0);
        for (int k = 0; k < 60; k++) cyc(0, 0, 0, 1);

        // R7 noise pattern
        cur_tag = "R7 noise stream";
        cyc(1, 32'h0F0F_3C3C, 0, 0);
        for (int k = 0; k < 200; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            cyc(0, 0, lcg[17], lcg[5]);
        end

        // R7 same seed, differing noise history gives a different word
        cur_tag = "R7 quiet run";
        cyc(1, 32'h5555_AAAA, 0, 0);
        repeat (3) cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 1);
        w_quiet = rand_word;
        cur_tag = "R7 noisy run";
        cyc(1, 32'h5555_AAAA, 0, 0);
        repeat (3) cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 1);
        w_noisy = rand_word;
        chk(w_noisy != w_quiet, "R7 noise changes word", w_noisy, ~w_quiet);

        // R8 seed reload reproduces sequence; R11 lanes run without requests
        cur_tag = "R8 R11 idle steps";
        cyc(1, 32'hCAFE_0001, 0, 0);
        repeat (17) cyc(0, 0, 0, 0);
        for (int k = 0; k < 10; k++) cyc(0, 0, 0, 1);

        repeat (3) cyc(0, 0, 0, 0);
        chk(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 32'd0);
        finish_run();
    end

endmodule